// File: doc/BRIEF.md
# Triggered Four-Channel Memory Copy Engine

This block copies blocks of 16-bit or 32-bit units from one memory address to another on behalf of a processor. It has four independent channels. Each channel holds a source address, a destination address, a unit count and a control word, all written through a small register port.

A channel starts in one of three ways:
- immediately when it is enabled;
- on a horizontal-blank pulse;
- on a vertical-blank pulse.

Each unit is moved as one read followed by one write on a single valid/ready memory master port. After each unit, the source and destination addresses step up, step down or stay fixed.

When a channel finishes, it can raise its own interrupt line. It then either disables itself or rearms for the next trigger. A rearmed channel reloads its count and, in one destination mode, also reloads its destination.

Top module: `trig_dma_ctrl`

## Requirements
- R1: After reset, all channel registers read as zero, `irq` is zero and `mem_req` is low. The register selects are 0 source, 1 destination, 2 count and 3 control.
- R2: A write to the source or destination register stores the value with bit 0 forced to zero.
- R3: Control bits are: 9 enable, 8 interrupt enable, 7:6 timing (0 immediate, 1 horizontal blank, 2 vertical blank, 3 special), 5 wide (32-bit units), 4 repeat, 3:2 source step, 1:0 destination step. Step codes are 0 increment, 1 decrement, 2 fixed, 3 increment. A step is 2 bytes for 16-bit units and 4 bytes for 32-bit units.
- R4: An immediate-timing channel copies `count` units when its enable bit changes from 0 to 1. The working source, destination and count are taken from the registers only at that 0-to-1 change.
- R5: For 32-bit units, bits 1:0 of both working addresses are cleared before the copy starts.
- R6: A count of 0 means ZERO_CNT_LO units on channels 0 to 2 and ZERO_CNT_HI units on the last channel.
- R7: After a copy without repeat, the enable bit (bit 9) reads back as 0 and all other control bits keep their values.
- R8: When the interrupt enable bit is set, the channel's `irq` bit pulses high for one cycle after the last write. When it is clear, no pulse occurs.
- R9: A blank pulse starts every enabled channel whose timing matches. Channels run one at a time, lowest-numbered first, so a higher channel's write to the same address lands last. Nothing moves before the pulse.
- R10: With repeat set, the channel stays enabled and its count reloads. Its destination reloads from the register only when the destination step code is 3; otherwise it continues from where it stopped. The source always continues.
- R11: Special timing starts no transfer on any channel, even when a blank pulse arrives.
- R12: Clearing the enable bit while a channel waits for its blank pulse cancels the pending copy.
- R13: `mem_req` and `mem_addr` stay unchanged while `mem_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_ch | input | 2 | Channel selected for register access |
| reg_sel | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| hblank_i | input | 1 | Horizontal-blank trigger pulse |
| vblank_i | input | 1 | Vertical-blank trigger pulse |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 write, 0 read |
| mem_wide | output | 1 | 1 for a 32-bit unit, 0 for a 16-bit unit |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data; upper half is zero for 16-bit units |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Read data, valid when `mem_ready` is high on a read |
| irq | output | 4 | Per-channel completion pulse |

## Verification
The bench builds the block with ZERO_CNT_LO set to 5 and ZERO_CNT_HI set to 9, and keeps every other parameter at its default. With these values, the zero-count default of both the low channels and the last channel finishes in a few dozen cycles. The bench can therefore compare the exact number of units moved against the untouched unit just past each block. Default widths keep the real 16-bit count register and the 32-bit addresses. Memory stalls, enabled in some scenarios, test request holding during copies.

// File: rtl/trig_dma_pkg.sv
package trig_dma_pkg;

    typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} fsm_e;

    localparam logic [1:0] TM_NOW = 2'd0;
    localparam logic [1:0] TM_HBL = 2'd1;
    localparam logic [1:0] TM_VBL = 2'd2;
    localparam logic [1:0] TM_SPC = 2'd3;

    localparam logic [1:0] STP_INC    = 2'd0;
    localparam logic [1:0] STP_DEC    = 2'd1;
    localparam logic [1:0] STP_FIX    = 2'd2;
    localparam logic [1:0] STP_INCRLD = 2'd3;

    localparam logic [1:0] SEL_SRC = 2'd0;
    localparam logic [1:0] SEL_DST = 2'd1;
    localparam logic [1:0] SEL_CNT = 2'd2;
    localparam logic [1:0] SEL_CTL = 2'd3;

    typedef struct packed {
        logic       en;
        logic       irq_en;
        logic [1:0] timing;
        logic       wide;
        logic       rpt;
        logic [1:0] src_step;
        logic [1:0] dst_step;
    } ctl_t;

endpackage

// File: rtl/trig_dma_step.sv
module trig_dma_step #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr_i,
    input  logic [1:0]    code_i,
    input  logic          wide_i,
    output logic [AW-1:0] next_o
);
    import trig_dma_pkg::*;

    logic [AW-1:0] delta;

    always_comb begin
        delta = wide_i ? AW'(4) : AW'(2);
        case (code_i)
            STP_DEC: next_o = addr_i - delta;
            STP_FIX: next_o = addr_i;
            default: next_o = addr_i + delta;
        endcase
    end
endmodule

// File: rtl/trig_dma_prio.sv
module trig_dma_prio #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/trig_dma_ctrl.sv
module trig_dma_ctrl #(
    parameter int NCH         = 4,
    parameter int AW          = 32,
    parameter int DW          = 32,
    parameter int CNT_W       = 16,
    parameter int ZERO_CNT_LO = 16384,
    parameter int ZERO_CNT_HI = 65536
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_we,
    input  logic [$clog2(NCH)-1:0] reg_ch,
    input  logic [1:0]             reg_sel,
    input  logic [AW-1:0]          reg_wdata,
    output logic [AW-1:0]          reg_rdata,
    input  logic                   hblank_i,
    input  logic                   vblank_i,
    output logic                   mem_req,
    output logic                   mem_we,
    output logic                   mem_wide,
    output logic [AW-1:0]          mem_addr,
    output logic [DW-1:0]          mem_wdata,
    input  logic                   mem_ready,
    input  logic [DW-1:0]          mem_rdata,
    output logic [NCH-1:0]         irq
);
    import trig_dma_pkg::*;

    localparam int CHW  = $clog2(NCH);
    localparam int CW   = CNT_W + 1;
    localparam int HW   = DW / 2;
    localparam int CTLW = $bits(ctl_t);

    typedef struct packed {
        logic [NCH-1:0][AW-1:0]    src;
        logic [NCH-1:0][AW-1:0]    dst;
        logic [NCH-1:0][AW-1:0]    wsrc;
        logic [NCH-1:0][AW-1:0]    wdst;
        logic [NCH-1:0][CNT_W-1:0] cnt;
        logic [NCH-1:0][CW-1:0]    wcnt;
        ctl_t [NCH-1:0]            ctl;
        logic [NCH-1:0]            pend;
        fsm_e                      fsm;
        logic [CHW-1:0]            act;
        logic [DW-1:0]             buf_;
        logic [NCH-1:0]            irq;
    } st_t;

    st_t st_d, st_q;

    logic           pick_any;
    logic [CHW-1:0] pick_idx;
    logic [AW-1:0]  src_nx, dst_nx;
    ctl_t           act_ctl, new_ctl;

    function automatic logic [CW-1:0] eff_cnt(input logic [CNT_W-1:0] c, input logic [CHW-1:0] ch);
        if (c != '0) return CW'(c);
        else if (ch == CHW'(NCH - 1)) return CW'(ZERO_CNT_HI);
        else return CW'(ZERO_CNT_LO);
    endfunction

    function automatic logic [AW-1:0] align(input logic [AW-1:0] a, input logic wide);
        return wide ? {a[AW-1:2], 2'b00} : a;
    endfunction

    assign act_ctl = st_q.ctl[st_q.act];
    assign new_ctl = ctl_t'(reg_wdata[CTLW-1:0]);

    trig_dma_prio #(.N(NCH), .IW(CHW)) prio_i (
        .req_i (st_q.pend),
        .any_o (pick_any),
        .idx_o (pick_idx)
    );

    trig_dma_step #(.AW(AW)) src_step_i (
        .addr_i (st_q.wsrc[st_q.act]),
        .code_i (act_ctl.src_step),
        .wide_i (act_ctl.wide),
        .next_o (src_nx)
    );

    trig_dma_step #(.AW(AW)) dst_step_i (
        .addr_i (st_q.wdst[st_q.act]),
        .code_i (act_ctl.dst_step),
        .wide_i (act_ctl.wide),
        .next_o (dst_nx)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = '0;

        for (int c = 0; c < NCH; c++) begin
            if (st_q.ctl[c].en &&
                ((hblank_i && st_q.ctl[c].timing == TM_HBL) ||
                 (vblank_i && st_q.ctl[c].timing == TM_VBL)))
                st_d.pend[c] = 1'b1;
        end

        case (st_q.fsm)
            ST_IDLE: begin
                if (pick_any) begin
                    st_d.act            = pick_idx;
                    st_d.wsrc[pick_idx] = align(st_q.wsrc[pick_idx], st_q.ctl[pick_idx].wide);
                    st_d.wdst[pick_idx] = align(st_q.wdst[pick_idx], st_q.ctl[pick_idx].wide);
                    st_d.fsm            = ST_RD;
                end
            end
            ST_RD: begin
                if (mem_ready) begin
                    st_d.buf_ = mem_rdata;
                    st_d.fsm  = ST_WR;
                end
            end
            default: begin
                if (mem_ready) begin
                    st_d.wsrc[st_q.act] = src_nx;
                    st_d.wdst[st_q.act] = dst_nx;
                    if (st_q.wcnt[st_q.act] <= CW'(1)) begin
                        st_d.fsm            = ST_IDLE;
                        st_d.irq[st_q.act]  = act_ctl.irq_en;
                        st_d.pend[st_q.act] = act_ctl.rpt && act_ctl.timing == TM_NOW;
                        if (act_ctl.rpt) begin
                            st_d.wcnt[st_q.act] = eff_cnt(st_q.cnt[st_q.act], st_q.act);
                            if (act_ctl.dst_step == STP_INCRLD)
                                st_d.wdst[st_q.act] = st_q.dst[st_q.act];
                        end else begin
                            st_d.ctl[st_q.act].en = 1'b0;
                        end
                    end else begin
                        st_d.wcnt[st_q.act] = st_q.wcnt[st_q.act] - CW'(1);
                        st_d.fsm            = ST_RD;
                    end
                end
            end
        endcase

        if (reg_we) begin
            case (reg_sel)
                SEL_SRC: st_d.src[reg_ch] = {reg_wdata[AW-1:1], 1'b0};
                SEL_DST: st_d.dst[reg_ch] = {reg_wdata[AW-1:1], 1'b0};
                SEL_CNT: st_d.cnt[reg_ch] = reg_wdata[CNT_W-1:0];
                default: begin
                    st_d.ctl[reg_ch] = new_ctl;
                    if (new_ctl.en && !st_q.ctl[reg_ch].en) begin
                        st_d.wsrc[reg_ch] = st_q.src[reg_ch];
                        st_d.wdst[reg_ch] = st_q.dst[reg_ch];
                        st_d.wcnt[reg_ch] = eff_cnt(st_q.cnt[reg_ch], reg_ch);
                        st_d.pend[reg_ch] = new_ctl.timing == TM_NOW;
                    end else if (!new_ctl.en &&
                                 !(st_q.fsm != ST_IDLE && st_q.act == reg_ch)) begin
                        st_d.pend[reg_ch] = 1'b0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.fsm <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (reg_sel)
            SEL_SRC: reg_rdata = st_q.src[reg_ch];
            SEL_DST: reg_rdata = st_q.dst[reg_ch];
            SEL_CNT: reg_rdata = AW'(st_q.cnt[reg_ch]);
            default: reg_rdata = AW'(st_q.ctl[reg_ch]);
        endcase
    end

    assign mem_req   = st_q.fsm != ST_IDLE;
    assign mem_we    = st_q.fsm == ST_WR;
    assign mem_wide  = act_ctl.wide;
    assign mem_addr  = (st_q.fsm == ST_WR) ? st_q.wdst[st_q.act] : st_q.wsrc[st_q.act];
    assign mem_wdata = act_ctl.wide ? st_q.buf_ : {{(DW - HW){1'b0}}, st_q.buf_[HW-1:0]};
    assign irq       = st_q.irq;

    // R13
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

    // R5
    wide_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_wide) |-> (mem_addr[1:0] == 2'b00));

    // R2
    half_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !mem_addr[0]);

    // R8
    irq_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq));

    // R8
    irq_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq != '0) |-> $past(mem_req && mem_we && mem_ready));

endmodule

// File: tb/trig_dma_ctrl_tb.sv
module trig_dma_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_ch = '0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        hblank_i = 1'b0;
    logic        vblank_i = 1'b0;
    logic        mem_req, mem_we, mem_wide, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  irq;

    logic        stall_en = 1'b0;
    logic        stall_q;
    logic [15:0] mem16 [0:1023];
    int          irq_seen [4];
    int          checks = 0;
    int          failures = 0;

    always #2.5 clk = ~clk;

    trig_dma_ctrl #(.ZERO_CNT_LO(5), .ZERO_CNT_HI(9)) dut_i (
        .clk, .rst_n, .reg_we, .reg_ch, .reg_sel, .reg_wdata, .reg_rdata,
        .hblank_i, .vblank_i, .mem_req, .mem_we, .mem_wide, .mem_addr,
        .mem_wdata, .mem_ready, .mem_rdata, .irq
    );

    assign mem_ready = mem_req && !(stall_en && stall_q);
    assign mem_rdata = mem_wide ? {mem16[{mem_addr[10:2], 1'b1}], mem16[{mem_addr[10:2], 1'b0}]}
                                : {16'h0, mem16[mem_addr[10:1]]};

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) mem16[i] <= 16'h1000 + 16'(i);
            for (int c = 0; c < 4; c++) irq_seen[c] <= 0;
            stall_q <= 1'b0;
        end else begin
            stall_q <= ~stall_q;
            if (mem_req && mem_we && mem_ready) begin
                if (mem_wide) begin
                    mem16[{mem_addr[10:2], 1'b0}] <= mem_wdata[15:0];
                    mem16[{mem_addr[10:2], 1'b1}] <= mem_wdata[31:16];
                end else begin
                    mem16[mem_addr[10:1]] <= mem_wdata[15:0];
                end
            end
            for (int c = 0; c < 4; c++) if (irq[c]) irq_seen[c] <= irq_seen[c] + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] ch, input logic [1:0] sel, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_ch = ch; reg_sel = sel; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] ch, input logic [1:0] sel, output logic [31:0] v);
        @(negedge clk);
        reg_ch = ch; reg_sel = sel;
        #1 v = reg_rdata;
    endtask

    task automatic setup(input logic [1:0] ch, input logic [31:0] s, input logic [31:0] d,
                         input logic [31:0] n, input logic [31:0] ctl);
        wr(ch, 2'd0, s);
        wr(ch, 2'd1, d);
        wr(ch, 2'd2, n);
        wr(ch, 2'd3, ctl);
    endtask

    task automatic pulse(input bit vb);
        @(negedge clk);
        if (vb) vblank_i = 1'b1; else hblank_i = 1'b1;
        @(negedge clk);
        vblank_i = 1'b0; hblank_i = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int c = 0; c < 4; c++)
            for (int s = 0; s < 4; s++) begin
                rd(2'(c), 2'(s), v);
                check("R1 reg zero", v, 32'h0);
            end
        check("R1 irq", {28'h0, irq}, 32'h0);
        check("R1 mem_req", {31'h0, mem_req}, 32'h0);
    endtask

    task automatic t_addr_mask();
        logic [31:0] v;
        wr(2'd2, 2'd0, 32'hFFFF_FFFF);
        rd(2'd2, 2'd0, v);
        check("R2 src bit0", v, 32'hFFFF_FFFE);
        wr(2'd2, 2'd1, 32'h1234_5677);
        rd(2'd2, 2'd1, v);
        check("R2 dst bit0", v, 32'h1234_5676);
    endtask

    task automatic t_imm16();
        logic [31:0] v;
        setup(2'd0, 32'h100, 32'h200, 32'd4, 32'h300);
        idle(40);
        for (int k = 0; k < 4; k++) check("R4 copy16", {16'h0, mem16[32'h100 + k]}, 32'h1080 + k);
        check("R4 count bound", {16'h0, mem16[32'h104]}, 32'h1104);
        rd(2'd0, 2'd3, v);
        check("R7 enable cleared", v, 32'h100);
        check("R8 irq pulse", irq_seen[0], 1);
    endtask

    task automatic t_wide();
        logic [31:0] v;
        stall_en = 1'b1;
        setup(2'd1, 32'h102, 32'h301, 32'd2, 32'h220);
        idle(60);
        for (int k = 0; k < 4; k++) check("R5 wide align", {16'h0, mem16[32'h180 + k]}, 32'h1080 + k);
        check("R8 no irq", irq_seen[1], 0);
        rd(2'd1, 2'd3, v);
        check("R7 bits kept", v, 32'h020);
        stall_en = 1'b0;
    endtask

    task automatic t_steps();
        setup(2'd2, 32'h60, 32'h400, 32'd3, 32'h206);
        idle(40);
        check("R3 dec/fixed", {16'h0, mem16[32'h200]}, 32'h102E);
        check("R3 fixed untouched", {16'h0, mem16[32'h201]}, 32'h1201);
        check("R3 fixed untouched lo", {16'h0, mem16[32'h1FF]}, 32'h11FF);
    endtask

    task automatic t_zero_cnt();
        stall_en = 1'b1;
        setup(2'd1, 32'h500, 32'h600, 32'd0, 32'h200);
        idle(80);
        for (int k = 0; k < 5; k++) check("R6 low default", {16'h0, mem16[32'h300 + k]}, 32'h1280 + k);
        check("R6 low bound", {16'h0, mem16[32'h305]}, 32'h1305);
        setup(2'd3, 32'h540, 32'h640, 32'd0, 32'h200);
        idle(120);
        for (int k = 0; k < 9; k++) check("R6 high default", {16'h0, mem16[32'h320 + k]}, 32'h12A0 + k);
        check("R6 high bound", {16'h0, mem16[32'h329]}, 32'h1329);
        stall_en = 1'b0;
    endtask

    task automatic t_hblank_order();
        logic [31:0] v;
        setup(2'd1, 32'h700, 32'h7F0, 32'd1, 32'h242);
        setup(2'd2, 32'h702, 32'h7F0, 32'd1, 32'h242);
        idle(20);
        check("R9 waits for pulse", {16'h0, mem16[32'h3F8]}, 32'h13F8);
        pulse(1'b0);
        idle(30);
        check("R9 order ch2 last", {16'h0, mem16[32'h3F8]}, 32'h1381);
        rd(2'd1, 2'd3, v);
        check("R9 ch1 done", v, 32'h042);
    endtask

    task automatic t_repeat();
        logic [31:0] v;
        setup(2'd3, 32'h080, 32'h0C0, 32'd2, 32'h293);
        setup(2'd0, 32'h0E0, 32'h1E0, 32'd1, 32'h290);
        pulse(1'b1);
        idle(30);
        check("R10 first pass", {16'h0, mem16[32'h60]}, 32'h1040);
        rd(2'd3, 2'd3, v);
        check("R10 stays enabled", v, 32'h293);
        pulse(1'b1);
        idle(30);
        check("R10 reload dst", {16'h0, mem16[32'h60]}, 32'h1042);
        check("R10 reload dst b", {16'h0, mem16[32'h61]}, 32'h1043);
        check("R10 reload no spill", {16'h0, mem16[32'h62]}, 32'h1062);
        check("R10 continue dst", {16'h0, mem16[32'hF1]}, 32'h1071);
        pulse(1'b0);
        idle(20);
        check("R10 hblank ignored", {16'h0, mem16[32'hF2]}, 32'h10F2);
        wr(2'd3, 2'd3, 32'h093);
        wr(2'd0, 2'd3, 32'h090);
    endtask

    task automatic t_cancel();
        setup(2'd2, 32'h100, 32'h7A0, 32'd1, 32'h240);
        wr(2'd2, 2'd3, 32'h040);
        pulse(1'b0);
        idle(20);
        check("R12 cancelled", {16'h0, mem16[32'h3D0]}, 32'h13D0);
    endtask

    task automatic t_special();
        setup(2'd0, 32'h100, 32'h7C0, 32'd1, 32'h2C0);
        idle(10);
        pulse(1'b0);
        pulse(1'b1);
        idle(20);
        check("R11 special ignored", {16'h0, mem16[32'h3E0]}, 32'h13E0);
        check("R11 no req", {31'h0, mem_req}, 32'h0);
        wr(2'd0, 2'd3, 32'h0C0);
    endtask

    initial begin
        #(5ns * 150000);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_addr_mask();
        t_imm16();
        t_wide();
        t_steps();
        t_zero_cnt();
        t_hblank_order();
        t_repeat();
        t_cancel();
        t_special();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule